// File: doc/BRIEF.md
# MSI Event Queue Router

This block takes message-signalled interrupt writes arriving from the host bridge and turns each one into a record in memory. It first checks the write address against one of two programmable windows. One window is for 32-bit writes and one is for 64-bit writes. The low bits of the MSI data word select an entry in a mapping table. That entry names one of several circular event queues. If the queue is running and has room, a two-word record goes out on the memory write port. The record goes to the queue's slot at its current tail, and the tail then advances.

Once an MSI has produced a record, it is locked out until software writes its clear register. When a queue would fill up, the record is dropped, the overflow flag is raised and the queue moves to an error state. A level interrupt per queue tells software that records are waiting. Software drains the records and then writes the new head pointer back.

Top module: `msi_eq_router`

## Requirements
- R1: After reset, every queue reads state idle (value 1), head 0, tail 0 and overflow 0, every map entry reads 0, all interrupts are low and no record is written.
- R2: A write is accepted only when its address bits 1:0 are zero. A 32-bit write must also have address bits 31:16 equal to the 32-bit window. A 64-bit write must also have address bits 63:16 equal to the 64-bit window. The 32-bit window reads back in bits 31:16 and the 64-bit window in bits 63:16.
- R3: The MSI number is the data word. A number at or above NUM_MSI is ignored. A map entry with valid (bit 63) clear is ignored. A map entry whose queue number (bits 5:0) is at or above NUM_Q is ignored.
- R4: Record word0 has bit 63 zero. Bits 62:56 hold 0x58 for a 32-bit write and 0x78 for a 64-bit write. Bits 55:46 hold length 1, bits 45:32 hold address bits 15:2, bits 31:16 hold the requester ID and bits 15:0 hold the MSI data. Word1 holds address bits 63:16 in bits 63:16 and zero in bits 15:0.
- R5: A record goes to byte address base + queue*8192 + tail*64, one cycle after the MSI. The tail then advances by one and wraps from 127 to 0.
- R6: An enqueue sets the MSI's written flag, which reads at map bit 62. While the flag is set, further writes of that MSI are ignored. Writing a value with bit 62 set to the MSI's clear register resets the flag.
- R7: State reads one-hot in bits 2:0: idle 1, active 2, error 4. Setting bit 44 in the control-set register moves idle to active. Setting bit 44 in the control-clear register moves active to idle. Setting bit 47 in the control-clear register moves error to idle.
- R8: Setting bit 57 in the control-set register forces the overflow flag, and setting bit 57 in the control-clear register clears it. The tail register shows the tail in bits 6:0 and overflow in bit 57.
- R9: When an active queue has tail+1 equal to head, the MSI writes nothing. Its flag is left clear, overflow is set and the state goes to error. A queue in error accepts nothing.
- R10: The interrupt of a queue is high exactly while the queue is active and its head differs from its tail.
- R11: A write to a map entry sets valid from bit 63 and the queue number from bits 5:0, and leaves the written flag unchanged.
- R12: An MSI aimed at an idle (disabled) queue writes nothing and leaves its written flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | MSI write present this cycle |
| msi_addr | input | 64 | MSI target address |
| msi_is64 | input | 1 | 1 = 64-bit MSI, 0 = 32-bit MSI |
| msi_rid | input | 16 | Requester ID of the writer |
| msi_data | input | 16 | MSI data word (MSI number) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Bits 11:8 group (0 map, 1 clear, 2 control-set, 3 control-clear, 4 state, 5 tail, 6 head, 7 window32, 8 window64, 9 base), bits 7:0 index |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational from reg_addr |
| mem_we | output | 1 | Record write strobe |
| mem_addr | output | 64 | Record byte address |
| mem_word0 | output | 64 | Record first word |
| mem_word1 | output | 64 | Record second word |
| irq | output | NUM_Q | Per-queue interrupt level |

## Verification
The hardest condition to reach is a full queue. Reaching it takes 127 accepted records into one queue. Because of the per-MSI lockout, each of those records must be preceded by a clear-register write. The bench therefore runs a loop that clears the same MSI and then fires it again, 127 times, checking each record address. The 128th attempt must then drop, raise overflow and move the queue to error. Software recovery follows: error-to-idle, overflow clear and re-enable. After that, moving the head lets one more record land in the last slot, so the tail wraps to 0.

// File: rtl/msi_eq_pkg.sv
package msi_eq_pkg;

    // Queue geometry: 8 KiB region of 64-byte records.
    localparam int PTR_W    = 7;
    localparam int REC_LG   = 6;

    typedef enum logic [2:0] {
        QS_IDLE   = 3'b001,
        QS_ACTIVE = 3'b010,
        QS_ERROR  = 3'b100
    } qstate_e;

    typedef struct packed {
        logic       valid;
        logic       written;
        logic [5:0] qnum;
    } map_ent_t;

    typedef struct packed {
        qstate_e            state;
        logic               ovf;
        logic [PTR_W-1:0]   head;
        logic [PTR_W-1:0]   tail;
    } queue_t;

    // Register groups, selected by reg_addr[11:8].
    localparam logic [3:0] G_MAP   = 4'd0;
    localparam logic [3:0] G_CLR   = 4'd1;
    localparam logic [3:0] G_CSET  = 4'd2;
    localparam logic [3:0] G_CCLR  = 4'd3;
    localparam logic [3:0] G_STATE = 4'd4;
    localparam logic [3:0] G_TAIL  = 4'd5;
    localparam logic [3:0] G_HEAD  = 4'd6;
    localparam logic [3:0] G_WIN32 = 4'd7;
    localparam logic [3:0] G_WIN64 = 4'd8;
    localparam logic [3:0] G_BASE  = 4'd9;

    localparam int B_VALID   = 63;
    localparam int B_WRITTEN = 62;
    localparam int B_OVF     = 57;
    localparam int B_E2I     = 47;
    localparam int B_EN      = 44;

    localparam logic [6:0] FT_MSI32 = 7'h58;
    localparam logic [6:0] FT_MSI64 = 7'h78;

endpackage

// File: rtl/msi_eq_window.sv
module msi_eq_window (
    input  logic [63:16] addr_hi,
    input  logic         is64,
    input  logic [15:0]  win32,
    input  logic [47:0]  win64,
    output logic         hit
);
    always_comb begin
        if (is64) hit = (addr_hi[63:16] == win64);
        else      hit = (addr_hi[31:16] == win32);
    end
endmodule

// File: rtl/msi_eq_record.sv
module msi_eq_record
    import msi_eq_pkg::*;
(
    input  logic [61:0] addr_dw,   // byte address bits 63:2
    input  logic        is64,
    input  logic [15:0] rid,
    input  logic [15:0] data,
    output logic [63:0] word0,
    output logic [63:0] word1
);
    always_comb begin
        word0 = {1'b0, (is64 ? FT_MSI64 : FT_MSI32), 10'd1,
                 addr_dw[13:0], rid, data};
        word1 = {addr_dw[61:14], 16'h0000};
    end
endmodule

// File: rtl/msi_eq_regrd.sv
module msi_eq_regrd
    import msi_eq_pkg::*;
#(
    parameter int NUM_MSI = 16,
    parameter int NUM_Q   = 4
) (
    input  map_ent_t [NUM_MSI-1:0] map_i,
    input  queue_t   [NUM_Q-1:0]   q_i,
    input  logic [15:0]            win32,
    input  logic [47:0]            win64,
    input  logic [63:0]            base,
    input  logic [11:0]            addr,
    output logic [63:0]            rdata
);
    localparam int MSI_IW = $clog2(NUM_MSI);
    localparam int Q_IW   = $clog2(NUM_Q);

    logic     msi_ok, q_ok;
    map_ent_t ent;
    queue_t   qs;

    always_comb begin
        msi_ok = {1'b0, addr[7:0]} < 9'(NUM_MSI);
        q_ok   = {1'b0, addr[7:0]} < 9'(NUM_Q);
        ent    = map_i[addr[MSI_IW-1:0]];
        qs     = q_i[addr[Q_IW-1:0]];
        rdata  = '0;
        case (addr[11:8])
            G_MAP:   if (msi_ok) rdata = {ent.valid, ent.written, 56'b0, ent.qnum};
            G_STATE: if (q_ok)   rdata = {61'b0, qs.state};
            G_TAIL:  if (q_ok)   rdata = {6'b0, qs.ovf, 50'b0, qs.tail};
            G_HEAD:  if (q_ok)   rdata = {57'b0, qs.head};
            G_WIN32: rdata = {32'b0, win32, 16'b0};
            G_WIN64: rdata = {win64, 16'b0};
            G_BASE:  rdata = base;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/msi_eq_router.sv
module msi_eq_router
    import msi_eq_pkg::*;
#(
    parameter int NUM_MSI = 16,
    parameter int NUM_Q   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msi_valid,
    input  logic [63:0]      msi_addr,
    input  logic             msi_is64,
    input  logic [15:0]      msi_rid,
    input  logic [15:0]      msi_data,
    input  logic             reg_we,
    input  logic [11:0]      reg_addr,
    input  logic [63:0]      reg_wdata,
    output logic [63:0]      reg_rdata,
    output logic             mem_we,
    output logic [63:0]      mem_addr,
    output logic [63:0]      mem_word0,
    output logic [63:0]      mem_word1,
    output logic [NUM_Q-1:0] irq
);
    localparam int MSI_IW = $clog2(NUM_MSI);
    localparam int Q_IW   = $clog2(NUM_Q);
    localparam int OFF_W  = Q_IW + PTR_W + REC_LG;

    typedef struct packed {
        map_ent_t [NUM_MSI-1:0] map;
        queue_t   [NUM_Q-1:0]   qs;
        logic [15:0]            win32;
        logic [47:0]            win64;
        logic [63:0]            base;
        logic                   we;
        logic [63:0]            waddr;
        logic [63:0]            w0;
        logic [63:0]            w1;
    } st_t;

    st_t st_q, st_d;

    logic              win_hit;
    logic [63:0]       rec_w0, rec_w1;
    logic [MSI_IW-1:0] idx;
    logic              data_ok, qnum_ok, accept;
    map_ent_t          ent;
    logic [Q_IW-1:0]   tq;
    queue_t            cur;
    logic [PTR_W-1:0]  nxt_tail;
    logic [OFF_W-1:0]  off;
    logic [MSI_IW-1:0] r_msi;
    logic [Q_IW-1:0]   r_q;
    logic              r_msi_ok, r_q_ok;
    logic [3*NUM_Q-1:0] qstate_flat;

    msi_eq_window u_win (
        .addr_hi (msi_addr[63:16]),
        .is64    (msi_is64),
        .win32   (st_q.win32),
        .win64   (st_q.win64),
        .hit     (win_hit)
    );

    msi_eq_record u_rec (
        .addr_dw (msi_addr[63:2]),
        .is64    (msi_is64),
        .rid     (msi_rid),
        .data    (msi_data),
        .word0   (rec_w0),
        .word1   (rec_w1)
    );

    msi_eq_regrd #(.NUM_MSI(NUM_MSI), .NUM_Q(NUM_Q)) u_rd (
        .map_i (st_q.map),
        .q_i   (st_q.qs),
        .win32 (st_q.win32),
        .win64 (st_q.win64),
        .base  (st_q.base),
        .addr  (reg_addr),
        .rdata (reg_rdata)
    );

    always_comb begin
        st_d     = st_q;
        st_d.we  = 1'b0;

        // MSI path
        idx      = msi_data[MSI_IW-1:0];
        data_ok  = {1'b0, msi_data} < 17'(NUM_MSI);
        ent      = st_q.map[idx];
        qnum_ok  = {1'b0, ent.qnum} < 7'(NUM_Q);
        tq       = ent.qnum[Q_IW-1:0];
        cur      = st_q.qs[tq];
        nxt_tail = cur.tail + 1'b1;
        off      = {tq, cur.tail, {REC_LG{1'b0}}};
        accept   = msi_valid && win_hit && (msi_addr[1:0] == 2'b00) && data_ok &&
                   ent.valid && !ent.written && qnum_ok && (cur.state == QS_ACTIVE);

        if (accept) begin
            if (nxt_tail == cur.head) begin
                st_d.qs[tq].ovf   = 1'b1;
                st_d.qs[tq].state = QS_ERROR;
            end else begin
                st_d.we               = 1'b1;
                st_d.waddr            = st_q.base + 64'(off);
                st_d.w0               = rec_w0;
                st_d.w1               = rec_w1;
                st_d.qs[tq].tail      = nxt_tail;
                st_d.map[idx].written = 1'b1;
            end
        end

        // Register path, applied after the MSI update
        r_msi    = reg_addr[MSI_IW-1:0];
        r_q      = reg_addr[Q_IW-1:0];
        r_msi_ok = {1'b0, reg_addr[7:0]} < 9'(NUM_MSI);
        r_q_ok   = {1'b0, reg_addr[7:0]} < 9'(NUM_Q);
        if (reg_we) begin
            case (reg_addr[11:8])
                G_MAP: if (r_msi_ok) begin
                    st_d.map[r_msi].valid = reg_wdata[B_VALID];
                    st_d.map[r_msi].qnum  = reg_wdata[5:0];
                end
                G_CLR: if (r_msi_ok && reg_wdata[B_WRITTEN])
                    st_d.map[r_msi].written = 1'b0;
                G_CSET: if (r_q_ok) begin
                    if (reg_wdata[B_EN] && st_d.qs[r_q].state == QS_IDLE)
                        st_d.qs[r_q].state = QS_ACTIVE;
                    if (reg_wdata[B_OVF])
                        st_d.qs[r_q].ovf = 1'b1;
                end
                G_CCLR: if (r_q_ok) begin
                    if (reg_wdata[B_EN] && st_d.qs[r_q].state == QS_ACTIVE)
                        st_d.qs[r_q].state = QS_IDLE;
                    if (reg_wdata[B_E2I] && st_d.qs[r_q].state == QS_ERROR)
                        st_d.qs[r_q].state = QS_IDLE;
                    if (reg_wdata[B_OVF])
                        st_d.qs[r_q].ovf = 1'b0;
                end
                G_TAIL:  if (r_q_ok) st_d.qs[r_q].tail = reg_wdata[PTR_W-1:0];
                G_HEAD:  if (r_q_ok) st_d.qs[r_q].head = reg_wdata[PTR_W-1:0];
                G_WIN32: st_d.win32 = reg_wdata[31:16];
                G_WIN64: st_d.win64 = reg_wdata[63:16];
                G_BASE:  st_d.base  = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < NUM_Q; i++) st_q.qs[i].state <= QS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar g = 0; g < NUM_Q; g++) begin : g_q
            assign irq[g] = (st_q.qs[g].state == QS_ACTIVE) &&
                            (st_q.qs[g].head != st_q.qs[g].tail);
            assign qstate_flat[3*g +: 3] = st_q.qs[g].state;
        end
    endgenerate

    assign mem_we    = st_q.we;
    assign mem_addr  = st_q.waddr;
    assign mem_word0 = st_q.w0;
    assign mem_word1 = st_q.w1;

endmodule

// File: rtl/msi_eq_router_chk.sv
module msi_eq_router_chk #(
    parameter int NUM_Q = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               msi_valid,
    input logic               mem_we,
    input logic [63:0]        mem_addr,
    input logic [63:0]        mem_word0,
    input logic [NUM_Q-1:0]   irq,
    input logic [3*NUM_Q-1:0] qstate_flat
);
    // R4: a written record always carries one of the two MSI type codes
    a_r4_type_code: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_word0[62:56] == 7'h58 || mem_word0[62:56] == 7'h78));

    // R4: reserved top bit of word0 is zero
    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !mem_word0[63]);

    // R5: records land on 64-byte boundaries
    a_r5_rec_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[5:0] == 6'd0));

    // R3: no record without an MSI in the previous cycle
    a_r3_write_needs_msi: assert property (@(posedge clk) disable iff (!rst_n)
        !msi_valid |=> !mem_we);

    generate
        for (genvar g = 0; g < NUM_Q; g++) begin : g_chk
            // R7: state is always one-hot
            a_r7_state_onehot: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot(qstate_flat[3*g +: 3]));
            // R10: interrupt only from an active queue
            a_r10_irq_active: assert property (@(posedge clk) disable iff (!rst_n)
                irq[g] |-> (qstate_flat[3*g +: 3] == 3'b010));
        end
    endgenerate
endmodule

bind msi_eq_router msi_eq_router_chk #(.NUM_Q(NUM_Q)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .msi_valid   (msi_valid),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_word0   (mem_word0),
    .irq         (irq),
    .qstate_flat (qstate_flat)
);

// File: tb/tb_msi_eq_router.sv
`timescale 1ns/1ps
module tb_msi_eq_router;
    localparam int NM = 16;
    localparam int NQ = 4;

    localparam logic [3:0] T_MAP = 4'd0, T_CLR = 4'd1, T_CSET = 4'd2, T_CCLR = 4'd3,
                           T_STATE = 4'd4, T_TAIL = 4'd5, T_HEAD = 4'd6,
                           T_WIN32 = 4'd7, T_WIN64 = 4'd8, T_BASE = 4'd9;
    localparam logic [63:0] BASE  = 64'h0000_0000_8000_0000;
    localparam logic [63:0] VAL   = 64'h8000_0000_0000_0000;
    localparam logic [63:0] WBIT  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] OVF   = 64'h0200_0000_0000_0000;
    localparam logic [63:0] EN    = 64'h0000_1000_0000_0000;
    localparam logic [63:0] E2I   = 64'h0000_8000_0000_0000;
    localparam logic [47:0] W64   = 48'h0000_1234_5678;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic msi_valid = 1'b0, msi_is64 = 1'b0;
    logic [63:0] msi_addr = '0;
    logic [15:0] msi_rid = '0, msi_data = '0;
    logic reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic mem_we;
    logic [63:0] mem_addr, mem_word0, mem_word1;
    logic [NQ-1:0] irq;

    int n_chk = 0, n_fail = 0;
    logic g_we;
    logic [63:0] g_addr, g_w0, g_w1, v;

    always #2.5 clk = ~clk;

    msi_eq_router #(.NUM_MSI(NM), .NUM_Q(NQ)) dut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] g, input int i, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = {g, 8'(i)}; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] g, input int i, output logic [63:0] d);
        reg_addr = {g, 8'(i)};
        #1;
        d = reg_rdata;
    endtask

    task automatic send(input logic [63:0] a, input logic is64, input logic [15:0] rid,
                        input logic [15:0] dat);
        @(negedge clk);
        msi_valid = 1'b1; msi_addr = a; msi_is64 = is64; msi_rid = rid; msi_data = dat;
        @(negedge clk);
        msi_valid = 1'b0;
        g_we = mem_we; g_addr = mem_addr; g_w0 = mem_word0; g_w1 = mem_word1;
    endtask

    function automatic logic [63:0] exp_w0(logic [63:0] a, logic is64, logic [15:0] rid,
                                           logic [15:0] dat);
        return {1'b0, (is64 ? 7'h78 : 7'h58), 10'd1, a[15:2], rid, dat};
    endfunction

    function automatic logic [63:0] a32(int lo);
        return 64'h0000_0000_FEE0_0000 | 64'(lo);
    endfunction

    function automatic logic [63:0] a64(int lo);
        return {W64, 16'(lo)};
    endfunction

    initial begin
        #(200000 * 5);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int q = 0; q < NQ; q++) begin
            rd(T_STATE, q, v); chk("R1 state", v, 64'd1);
            rd(T_TAIL, q, v);  chk("R1 tail", v, 64'd0);
            rd(T_HEAD, q, v);  chk("R1 head", v, 64'd0);
        end
        for (int m = 0; m < NM; m++) begin
            rd(T_MAP, m, v); chk("R1 map", v, 64'd0);
        end
        chk("R1 irq", 64'(irq), 64'd0);
        chk("R1 mem_we", 64'(mem_we), 64'd0);

        // Window and base setup, R2 readback
        wr(T_WIN32, 0, 64'h0000_0000_FEE0_0000);
        wr(T_WIN64, 0, {W64, 16'h0000});
        wr(T_BASE, 0, BASE);
        rd(T_WIN32, 0, v); chk("R2 win32 readback", v, 64'h0000_0000_FEE0_0000);
        rd(T_WIN64, 0, v); chk("R2 win64 readback", v, {W64, 16'h0000});

        // R12 disabled queue ignores MSI
        wr(T_MAP, 3, VAL | 64'd1);
        send(a32(12), 1'b0, 16'h0103, 16'd3);
        chk("R12 no write to idle queue", 64'(g_we), 64'd0);
        rd(T_MAP, 3, v); chk("R12 flag stays clear", v, VAL | 64'd1);

        // R7 enable all queues
        for (int q = 0; q < NQ; q++) begin
            wr(T_CSET, q, EN);
            rd(T_STATE, q, v); chk("R7 enable to active", v, 64'd2);
        end

        // R4 R5 sweep over every MSI, alternating widths
        for (int m = 0; m < NM; m++) begin
            wr(T_MAP, m, VAL | 64'(m % NQ));
        end
        for (int m = 0; m < NM; m++) begin
            logic [63:0] a;
            logic is64;
            is64 = m[0];
            a = is64 ? a64(m * 4) : a32(m * 4);
            send(a, is64, 16'(16'h0100 + m), 16'(m));
            chk("R5 write strobe", 64'(g_we), 64'd1);
            chk("R5 record address", g_addr, BASE + 64'((m % NQ) * 8192 + (m / NQ) * 64));
            chk("R4 word0", g_w0, exp_w0(a, is64, 16'(16'h0100 + m), 16'(m)));
            chk("R4 word1", g_w1, {a[63:16], 16'h0000});
        end
        for (int q = 0; q < NQ; q++) begin
            rd(T_TAIL, q, v); chk("R5 tail after sweep", v, 64'd4);
        end
        chk("R10 irq all pending", 64'(irq), 64'hF);
        rd(T_MAP, 5, v); chk("R6 R11 map readback", v, VAL | WBIT | 64'd1);

        // R11 map write keeps written flag
        wr(T_MAP, 5, VAL | 64'd1);
        rd(T_MAP, 5, v); chk("R11 flag kept on map write", v, VAL | WBIT | 64'd1);

        // R6 lockout and clear
        send(a32(0), 1'b0, 16'h0100, 16'd0);
        chk("R6 locked MSI ignored", 64'(g_we), 64'd0);
        rd(T_TAIL, 0, v); chk("R6 tail unchanged", v, 64'd4);
        wr(T_CLR, 0, WBIT);
        rd(T_MAP, 0, v); chk("R6 flag cleared", v, VAL);
        send(a32(0), 1'b0, 16'h0100, 16'd0);
        chk("R6 accepted after clear", 64'(g_we), 64'd1);
        chk("R6 address after clear", g_addr, BASE + 64'd256);
        rd(T_TAIL, 0, v); chk("R6 tail advanced", v, 64'd5);

        // R10 head catch-up drops irq
        wr(T_HEAD, 0, 64'd5);
        chk("R10 irq after head write", 64'(irq), 64'hE);

        // R2 window misses
        wr(T_CLR, 1, WBIT);
        send(64'h0000_0000_FEE1_0004, 1'b0, 16'h1, 16'd1);
        chk("R2 32-bit wrong window", 64'(g_we), 64'd0);
        send({48'h0000_1234_5679, 16'h0004}, 1'b1, 16'h1, 16'd1);
        chk("R2 64-bit wrong window", 64'(g_we), 64'd0);
        send({W64, 16'h0004}, 1'b0, 16'h1, 16'd1);
        chk("R2 32-bit flag uses 32-bit window", 64'(g_we), 64'd0);
        send(a32(5), 1'b0, 16'h1, 16'd1);
        chk("R2 misaligned", 64'(g_we), 64'd0);
        send(a32(4), 1'b0, 16'h1, 16'd1);
        chk("R2 hit after misses", 64'(g_we), 64'd1);
        chk("R2 hit address", g_addr, BASE + 64'(8192 + 4 * 64));

        // R3 ignored numbers and entries
        send(a32(0), 1'b0, 16'h1, 16'(NM));
        chk("R3 MSI number out of range", 64'(g_we), 64'd0);
        wr(T_MAP, 2, 64'd2);
        wr(T_CLR, 2, WBIT);
        send(a32(0), 1'b0, 16'h1, 16'd2);
        chk("R3 invalid entry", 64'(g_we), 64'd0);
        wr(T_MAP, 4, VAL | 64'd5);
        wr(T_CLR, 4, WBIT);
        send(a32(0), 1'b0, 16'h1, 16'd4);
        chk("R3 queue number out of range", 64'(g_we), 64'd0);

        // R7 R12 disable queue 3
        wr(T_CCLR, 3, EN);
        rd(T_STATE, 3, v); chk("R7 disable to idle", v, 64'd1);
        chk("R10 irq after disable", 64'(irq), 64'h6);
        wr(T_CLR, 3, WBIT);
        send(a32(12), 1'b0, 16'h0103, 16'd3);
        chk("R12 disabled queue drops", 64'(g_we), 64'd0);
        rd(T_MAP, 3, v); chk("R12 flag clear on drop", v, VAL | 64'd3);

        // R9 fill queue 2 with MSI 6
        wr(T_TAIL, 2, 64'd0);
        wr(T_HEAD, 2, 64'd0);
        for (int i = 0; i < 127; i++) begin
            wr(T_CLR, 6, WBIT);
            send(a32(24), 1'b0, 16'h6, 16'd6);
            chk("R9 fill write", 64'(g_we), 64'd1);
            chk("R5 fill address", g_addr, BASE + 64'(2 * 8192 + i * 64));
        end
        wr(T_CLR, 6, WBIT);
        send(a32(24), 1'b0, 16'h6, 16'd6);
        chk("R9 full drops", 64'(g_we), 64'd0);
        rd(T_TAIL, 2, v);  chk("R9 overflow in tail", v, OVF | 64'd127);
        rd(T_STATE, 2, v); chk("R9 error state", v, 64'd4);
        rd(T_MAP, 6, v);   chk("R9 flag clear on drop", v, VAL | 64'd2);
        chk("R10 irq off in error", 64'(irq[2]), 64'd0);
        send(a32(24), 1'b0, 16'h6, 16'd6);
        chk("R9 error queue drops", 64'(g_we), 64'd0);

        // R7 R8 recovery
        wr(T_CCLR, 2, E2I);
        rd(T_STATE, 2, v); chk("R7 error to idle", v, 64'd1);
        rd(T_TAIL, 2, v);  chk("R8 overflow kept", v, OVF | 64'd127);
        wr(T_CCLR, 2, OVF);
        rd(T_TAIL, 2, v);  chk("R8 overflow cleared", v, 64'd127);
        wr(T_CSET, 2, OVF);
        rd(T_TAIL, 2, v);  chk("R8 overflow forced", v, OVF | 64'd127);
        wr(T_CCLR, 2, OVF);
        wr(T_CSET, 2, EN);
        rd(T_STATE, 2, v); chk("R7 re-enable", v, 64'd2);

        // R5 wrap
        wr(T_HEAD, 2, 64'd64);
        wr(T_CLR, 6, WBIT);
        send(a32(24), 1'b0, 16'h6, 16'd6);
        chk("R5 last slot write", 64'(g_we), 64'd1);
        chk("R5 last slot address", g_addr, BASE + 64'(2 * 8192 + 127 * 64));
        rd(T_TAIL, 2, v); chk("R5 tail wraps", v, 64'd0);
        chk("R10 irq after wrap", 64'(irq[2]), 64'd1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule